// File: doc/BRIEF.md
# Self-calibrating Manchester bit decoder

This block turns a Manchester-coded serial line into a stream of decoded bits, each marked by a one-cycle valid strobe. The line is oversampled by the system clock, which must run at least six times faster than the bit rate. No fixed bit rate is configured. The block learns the rate by itself: it measures how many clocks pass between successive line transitions and records which interval lengths occurred over a window of transitions. From that record it derives the threshold that separates half-bit intervals from full-bit intervals.

Calibration runs without a break. Each window ends with a search of the interval histogram. A successful search installs a new threshold. A failed search raises a current-failure flag and a sticky failure flag, and the previous threshold stays in use. Software reads the histogram and both flags. A status-read strobe clears the sticky flag. No decoded bit leaves the block before the first successful calibration.

Top module: `manchester_cal_decoder`

## Requirements
- R1: While reset is held and right after it is released, `bit_valid`, `interval_map`, `cal_fail_now` and `cal_fail_seen` are all 0.
- R2: The line passes through a synchronizer, and the block counts system clocks between successive transitions of the synchronized level. Over each window of `WIN_TRANS` intervals (default 1024), bit n-1 of the window's map is set exactly when an interval of n clocks was seen, for n from 1 to `HIST_W` (default 11). An interval longer than `HIST_W` clocks sets no bit. Each lane rate is checked with its own map value: half-bit 3 gives 0x024, half-bit 5 gives 0x210, and half-bit 7 gives 0x040, because the 14-clock interval saturates.
- R3: At each window end the block searches the map from bit 0 upward. It looks for the lowest index i (i >= 1) where bit i-1 is set, bit i is clear, and some bit above i is set. The threshold becomes i+1 clocks. An interval shorter than the threshold is short (half bit); an interval at or above it is long (full bit).
- R4: `bit_valid` stays 0 until a window has completed with a successful search.
- R5: `cal_fail_now` shows the outcome of the most recent window only (1 = search failed). A failed window leaves the threshold as it was.
- R6: `cal_fail_seen` is set by any failed window and cleared by a one-cycle pulse on `status_rd`. If both happen in the same cycle, the set wins.
- R7: When locked, every mid-bit transition produces one decoded bit. That bit equals the line level just after the transition, so a low-to-high mid-bit transition gives 1. A long interval always ends on a mid-bit transition. A short interval alternates between a bit boundary and a mid-bit transition.
- R8: An interval longer than `HIST_W` clocks drops lock. No bit is produced until the next long interval, and that interval's own bit is the first one delivered.
- R9: `interval_map` changes only when a window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw Manchester-coded serial line |
| status_rd | input | 1 | One-cycle strobe; clears the sticky failure flag |
| bit_out | output | 1 | Last decoded bit |
| bit_valid | output | 1 | One-cycle strobe; `bit_out` holds a new bit |
| interval_map | output | HIST_W | Interval histogram of the last completed window |
| cal_fail_now | output | 1 | The last window's threshold search failed |
| cal_fail_seen | output | 1 | A window has failed since the last status read |

## Verification
The assertions assume that the line stays steady for whole system-clock periods. They also assume that `status_rd` is a single-cycle pulse and that interval lengths come only from real line transitions, since the synchronizer sets the time base. The stimulus changes the line only on falling clock edges. Each half bit lasts an exact whole number of clocks (3, 5 or 7). Every burst starts from an idle-high line with a fixed 0-then-1 preamble, so the point where lock is regained is known. Each rate runs long enough that at least one window consists entirely of that rate before its map and flags are compared.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
   // Default geometry of the calibrating decoder
   localparam int unsigned MCD_HIST_W_DEF = 11;
   localparam int unsigned MCD_WIN_DEF    = 1024;
   localparam int unsigned MCD_SYNC_DEF   = 2;

   // Position of the last accepted transition inside the bit cell
   typedef enum logic [1:0] {
      LOCK_NONE = 2'd0,   // no lock, waiting for a long interval
      LOCK_MID  = 2'd1,   // last transition was mid-bit
      LOCK_EDGE = 2'd2    // last transition was a bit boundary
   } lock_e;
endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic level,
   output logic edge_ev
);
   logic [STAGES-1:0] chain;
   logic              level_d;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= 1'b0;
               else        chain[k] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= 1'b0;
               else        chain[k] <= chain[k-1];
            end
         end
      end
   endgenerate

   assign level = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign edge_ev = level ^ level_d;
endmodule

// File: rtl/mcd_interval.sv
module mcd_interval #(
   parameter int unsigned HIST_W = 11,
   localparam int unsigned LEN_W = $clog2(HIST_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_ev,
   output logic             iv_valid,
   output logic [LEN_W-1:0] iv_len
);
   localparam logic [LEN_W-1:0] SAT = LEN_W'(HIST_W + 1);

   logic [LEN_W-1:0] run_cnt;

   // Starts saturated, so the first interval after reset never sets a map bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_cnt <= SAT;
      else if (edge_ev)    run_cnt <= LEN_W'(1);
      else if (run_cnt != SAT) run_cnt <= run_cnt + LEN_W'(1);
   end

   assign iv_valid = edge_ev;
   assign iv_len   = run_cnt;

   // R2
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iv_valid |-> (iv_len != '0 && iv_len <= SAT));
endmodule

// File: rtl/mcd_calib.sv
module mcd_calib #(
   parameter int unsigned HIST_W    = 11,
   parameter int unsigned WIN_TRANS = 1024,
   localparam int unsigned LEN_W = $clog2(HIST_W + 2),
   localparam int unsigned WIN_W = $clog2(WIN_TRANS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iv_valid,
   input  logic [LEN_W-1:0]  iv_len,
   input  logic              status_rd,
   output logic [HIST_W-1:0] map_out,
   output logic [LEN_W-1:0]  thr,
   output logic              cal_ok,
   output logic              fail_now,
   output logic              fail_seen
);
   logic [HIST_W-1:0] map_acc;
   logic [HIST_W-1:0] map_next;
   logic [WIN_W-1:0]  win_cnt;
   logic              win_end;
   logic              srch_ok;
   logic [LEN_W-1:0]  srch_thr;

   // Mark the bin of the incoming interval; saturated lengths mark nothing
   always_comb begin
      map_next = map_acc;
      for (int n = 1; n <= int'(HIST_W); n++) begin
         if (iv_len == LEN_W'(n)) map_next[n-1] = 1'b1;
      end
   end

   assign win_end = iv_valid && (win_cnt == WIN_W'(WIN_TRANS - 1));

   // Lowest clear bin that follows a set bin and has a set bin above it
   always_comb begin
      srch_ok  = 1'b0;
      srch_thr = '0;
      for (int i = 1; i < int'(HIST_W) - 1; i++) begin
         if (!srch_ok && map_next[i-1] && !map_next[i] &&
             ((map_next >> (i + 1)) != '0)) begin
            srch_ok  = 1'b1;
            srch_thr = LEN_W'(i + 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_acc  <= '0;
         win_cnt  <= '0;
         map_out  <= '0;
         thr      <= '0;
         cal_ok   <= 1'b0;
         fail_now <= 1'b0;
      end else if (win_end) begin
         map_acc  <= '0;
         win_cnt  <= '0;
         map_out  <= map_next;
         fail_now <= !srch_ok;
         if (srch_ok) begin
            thr    <= srch_thr;
            cal_ok <= 1'b1;
         end
      end else if (iv_valid) begin
         map_acc <= map_next;
         win_cnt <= win_cnt + WIN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    fail_seen <= 1'b0;
      else if (win_end && !srch_ok)  fail_seen <= 1'b1;
      else if (status_rd)            fail_seen <= 1'b0;
   end

   // R9
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(map_out));
   // R5
   thr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !srch_ok) |=> ($stable(thr) && fail_now));
   // R6
   seen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !(win_end && !srch_ok)) |=> !fail_seen);
   // R6
   seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_seen) |-> fail_now);
   // R3
   thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_ok |-> (thr >= LEN_W'(2) && thr <= LEN_W'(HIST_W - 1)));
endmodule

// File: rtl/mcd_bitrec.sv
module mcd_bitrec
   import mcd_pkg::*;
#(
   parameter int unsigned HIST_W = 11,
   localparam int unsigned LEN_W = $clog2(HIST_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iv_valid,
   input  logic [LEN_W-1:0] iv_len,
   input  logic             level,
   input  logic [LEN_W-1:0] thr,
   input  logic             cal_ok,
   output logic             bit_out,
   output logic             bit_valid
);
   lock_e lock_st;
   logic  too_long;
   logic  is_long;

   assign too_long = iv_len > LEN_W'(HIST_W);
   assign is_long  = iv_len >= thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_st   <= LOCK_NONE;
         bit_out   <= 1'b0;
         bit_valid <= 1'b0;
      end else begin
         bit_valid <= 1'b0;
         if (iv_valid) begin
            if (!cal_ok || too_long) begin
               lock_st <= LOCK_NONE;
            end else if (is_long) begin
               lock_st   <= LOCK_MID;
               bit_out   <= level;
               bit_valid <= 1'b1;
            end else begin
               case (lock_st)
                  LOCK_MID:  lock_st <= LOCK_EDGE;
                  LOCK_EDGE: begin
                     lock_st   <= LOCK_MID;
                     bit_out   <= level;
                     bit_valid <= 1'b1;
                  end
                  default:   lock_st <= LOCK_NONE;
               endcase
            end
         end
      end
   end

   // R4
   valid_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> cal_ok);
   // R7
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> ($past(iv_valid) && bit_out == $past(level)));
   // R8
   sat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && too_long) |=> !bit_valid);
endmodule

// File: rtl/manchester_cal_decoder.sv
module manchester_cal_decoder
   import mcd_pkg::*;
#(
   parameter int unsigned HIST_W      = MCD_HIST_W_DEF,
   parameter int unsigned WIN_TRANS   = MCD_WIN_DEF,
   parameter int unsigned SYNC_STAGES = MCD_SYNC_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              status_rd,
   output logic              bit_out,
   output logic              bit_valid,
   output logic [HIST_W-1:0] interval_map,
   output logic              cal_fail_now,
   output logic              cal_fail_seen
);
   localparam int unsigned LEN_W = $clog2(HIST_W + 2);

   generate
      if (HIST_W < 3) begin : g_bad_hist
         $error("HIST_W must be at least 3");
      end
      if (WIN_TRANS < 2) begin : g_bad_win
         $error("WIN_TRANS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             level;
   logic             edge_ev;
   logic             iv_valid;
   logic [LEN_W-1:0] iv_len;
   logic [LEN_W-1:0] thr;
   logic             cal_ok;

   mcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .level   (level),
      .edge_ev (edge_ev)
   );

   mcd_interval #(.HIST_W(HIST_W)) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_ev  (edge_ev),
      .iv_valid (iv_valid),
      .iv_len   (iv_len)
   );

   mcd_calib #(.HIST_W(HIST_W), .WIN_TRANS(WIN_TRANS)) u_calib (
      .clk       (clk),
      .rst_n     (rst_n),
      .iv_valid  (iv_valid),
      .iv_len    (iv_len),
      .status_rd (status_rd),
      .map_out   (interval_map),
      .thr       (thr),
      .cal_ok    (cal_ok),
      .fail_now  (cal_fail_now),
      .fail_seen (cal_fail_seen)
   );

   mcd_bitrec #(.HIST_W(HIST_W)) u_bitrec (
      .clk       (clk),
      .rst_n     (rst_n),
      .iv_valid  (iv_valid),
      .iv_len    (iv_len),
      .level     (level),
      .thr       (thr),
      .cal_ok    (cal_ok),
      .bit_out   (bit_out),
      .bit_valid (bit_valid)
   );
endmodule

// File: tb/test_manchester_cal_decoder.sv
module test_manchester_cal_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_in = 1'b1;
   logic        status_rd = 1'b0;
   logic        bit_out;
   logic        bit_valid;
   logic [10:0] interval_map;
   logic        cal_fail_now;
   logic        cal_fail_seen;

   int checks = 0;
   int errors = 0;
   bit exp_q[$];
   bit expect_on = 1'b0;
   bit count_early = 1'b0;
   int early_valid = 0;

   always #4 clk = ~clk;

   manchester_cal_decoder i_manchester_cal_decoder (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_in       (line_in),
      .status_rd     (status_rd),
      .bit_out       (bit_out),
      .bit_valid     (bit_valid),
      .interval_map  (interval_map),
      .cal_fail_now  (cal_fail_now),
      .cal_fail_seen (cal_fail_seen)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected bits as the design delivers them (R7, R8)
   always @(negedge clk) begin
      if (bit_valid) begin
         if (count_early) early_valid++;
         if (expect_on) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7", "unexpected decoded bit", int'(bit_out), -1);
            end else begin
               bit e;
               e = exp_q.pop_front();
               chk(bit_out == e, "R7", "decoded bit", int'(bit_out), int'(e));
            end
         end
      end
   end

   // Driver: one Manchester cell, low-to-high mid transition encodes 1
   task automatic send_bit(input bit b, input int half, input bit push);
      if (push) exp_q.push_back(b);
      line_in = ~b;
      repeat (half) @(negedge clk);
      line_in = b;
      repeat (half) @(negedge clk);
   endtask

   task automatic idle(input int n);
      line_in = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic train(input int half, input int n);
      for (int k = 0; k < n; k++) send_bit(1'($urandom & 1), half, 1'b0);
   endtask

   // Preamble 0,1 from idle high: the 0 is lost to the saturated gap (R8)
   task automatic burst(input int half, input int n);
      send_bit(1'b0, half, 1'b0);
      send_bit(1'b1, half, 1'b1);
      for (int k = 0; k < n; k++) send_bit(1'($urandom & 1), half, 1'b1);
      idle(40);
   endtask

   initial begin
      logic [10:0] map_hold;
      repeat (5) @(negedge clk);
      // R1 reset values
      chk(bit_valid == 1'b0, "R1", "bit_valid in reset", int'(bit_valid), 0);
      chk(interval_map == 11'h000, "R1", "map in reset", int'(interval_map), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cal_fail_now == 1'b0, "R1", "fail_now after reset", int'(cal_fail_now), 0);
      chk(cal_fail_seen == 1'b0, "R1", "fail_seen after reset", int'(cal_fail_seen), 0);
      idle(20);

      // R4: fewer than one window of transitions, nothing decoded yet
      count_early = 1'b1;
      train(3, 500);
      count_early = 1'b0;
      chk(early_valid == 0, "R4", "bits before calibration", early_valid, 0);

      train(3, 800);
      idle(40);
      // R2: intervals of 3 and 6 clocks
      chk(interval_map == 11'h024, "R2", "map at half 3", int'(interval_map), 'h024);
      chk(cal_fail_now == 1'b0, "R5", "fail_now at half 3", int'(cal_fail_now), 0);
      chk(cal_fail_seen == 1'b0, "R6", "fail_seen at half 3", int'(cal_fail_seen), 0);

      // R9: quiet line, no window end, map unchanged
      map_hold = interval_map;
      idle(60);
      chk(interval_map == map_hold, "R9", "map without window end",
          int'(interval_map), int'(map_hold));

      // R7 R8: decode at half 3 (threshold 4)
      expect_on = 1'b1;
      burst(3, 64);
      expect_on = 1'b0;
      chk(exp_q.size() == 0, "R7", "bits left undelivered at half 3", exp_q.size(), 0);
      exp_q.delete();

      // R2 R3: retrain at half 5, threshold becomes 6
      train(5, 2200);
      idle(40);
      chk(interval_map == 11'h210, "R2", "map at half 5", int'(interval_map), 'h210);
      chk(cal_fail_now == 1'b0, "R5", "fail_now at half 5", int'(cal_fail_now), 0);
      expect_on = 1'b1;
      burst(5, 64);
      expect_on = 1'b0;
      chk(exp_q.size() == 0, "R3", "bits left undelivered at half 5", exp_q.size(), 0);
      exp_q.delete();

      // R2 R5 R6: half 7 gives 7 and saturated 14, search fails
      train(7, 2500);
      idle(40);
      chk(interval_map == 11'h040, "R2", "map at half 7 (14 saturates)",
          int'(interval_map), 'h040);
      chk(cal_fail_now == 1'b1, "R5", "fail_now after failed window", int'(cal_fail_now), 1);
      chk(cal_fail_seen == 1'b1, "R6", "fail_seen after failed window", int'(cal_fail_seen), 1);

      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      @(negedge clk);
      chk(cal_fail_seen == 1'b0, "R6", "fail_seen after status read", int'(cal_fail_seen), 0);
      chk(cal_fail_now == 1'b1, "R5", "fail_now kept over status read", int'(cal_fail_now), 1);

      // R5: threshold 6 kept through failures, half 5 still decodes
      expect_on = 1'b1;
      burst(5, 64);
      expect_on = 1'b0;
      chk(exp_q.size() == 0, "R5", "bits left undelivered after failure", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule